// File: doc/BRIEF.md
# Coupled-Integrator Resonator Notch Cell

This block is one cell of a frequency-separating bank used to analyse a converter's output on chip. It takes one signed converter sample per clock, qualified by a valid strobe. Two cross-coupled integrators form a damped second-order resonance. The cell produces two results: a bandpass output that keeps the component near the resonance, and a notch output that keeps everything else. The notch output is the input minus the bandpass output, so the two outputs together always add back up to the input.

The resonance frequency comes from one coupling coefficient. It is fixed at elaboration time as a signed-digit constant: one mask of plus digits and one mask of minus digits, with 14 fractional bits. The cell multiplies by it using shifts, adds and subtracts only, with no hardware multiplier. The damping, which sets the bandwidth, is a plain arithmetic right shift (3 bits by default). The pole polynomial is 1 − (2 − k2 − k1²)z⁻¹ + (1 − k2)z⁻², where k2 = 2^−DAMP_SH.

Top module: `ldi_notch_cell`

## Requirements
- R1: While reset is high at a clock edge, after that edge out_valid is 0, bp_out and notch_out are 0, and both integrator states are 0.
- R2: out_valid is high in the cycle after a cycle in which in_valid was high, and low after a cycle in which it was low.
- R3: The sample is taken as a two's-complement ADC_W-bit value, sign-extended and multiplied by 2^FRAC, giving x. After reset, a first sample of −1 yields bp_out = −1024 and notch_out = −15360 in raw units.
- R4: On each valid sample, the forward state becomes a' = a − (a >>> DAMP_SH) − ((b·K) >>> 14) + x. Here K = K1_POS − K1_NEG and >>> is a floor shift.
- R5: On the same sample, and in the same cycle, the feedback state becomes b' = b + ((a'·K) >>> 14). It uses the new forward state a', with no delay.
- R6: bp_out = (a' + a) >>> (DAMP_SH+1), where a is the forward state before the update.
- R7: notch_out = x − bp_out, saturated to the output width.
- R8: A cycle with in_valid low leaves both states and both outputs unchanged. The next valid sample continues as if the gap had not occurred.
- R9: State sums saturate to ±(2^(SW−1)) and outputs saturate to ±(2^(OW−1)) instead of wrapping. A full-scale square wave at the resonance drives bp_out to its limit.
- R10: Reset applied in the middle of a stream clears the states, so the response that follows is the same as from power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample qualifier |
| in_sample | input | ADC_W | Signed converter sample |
| out_valid | output | 1 | Results updated this cycle |
| bp_out | output | ADC_W+FRAC | Signed bandpass result, FRAC fractional bits |
| notch_out | output | ADC_W+FRAC | Signed notch result, FRAC fractional bits |

## Verification
The bench checks every output against a bit-exact model of the recurrences, so floor rounding, the update order and the bandwidth shift are all covered. A cell that used the old forward state in the feedback integrator, or that rounded instead of flooring, drifts away from the model within a few samples.

Idle gaps inside a stream are a corner case: a cell that advanced its state on those gaps would diverge as soon as the stream resumed. A resonant full-scale square wave pushes the outputs into their limits; wrapping instead of clamping shows up as a jump of sign. A reset in mid-stream followed by a known small sample checks that the state is truly cleared.

// File: rtl/ldi_notch_cell.sv
module ldi_notch_cell #(
  parameter int ADC_W   = 12,
  parameter int FRAC    = 14,
  parameter int GUARD   = 4,
  parameter int K1_W    = 16,
  parameter int K1_FRAC = 14,
  parameter logic [K1_W-1:0] K1_POS = 16'h2800,
  parameter logic [K1_W-1:0] K1_NEG = 16'h0080,
  parameter int DAMP_SH = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           in_valid,
  input  logic signed [ADC_W-1:0]        in_sample,
  output logic                           out_valid,
  output logic signed [ADC_W+FRAC-1:0]   bp_out,
  output logic signed [ADC_W+FRAC-1:0]   notch_out
);
  localparam int OW = ADC_W + FRAC;
  localparam int SW = OW + GUARD;
  localparam int PW = SW + K1_W + 2;
  localparam logic signed [PW-1:0] S_MAX = {{(PW-SW+1){1'b0}}, {(SW-1){1'b1}}};
  localparam logic signed [PW-1:0] S_MIN = {{(PW-SW+1){1'b1}}, {(SW-1){1'b0}}};
  localparam logic signed [PW-1:0] O_MAX = {{(PW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [PW-1:0] O_MIN = {{(PW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  logic signed [SW-1:0] a_q, b_q, a_nx, b_nx;
  logic signed [OW-1:0] x_w, bp_nx, nt_nx;

  function automatic logic signed [PW-1:0] ext_s(input logic signed [SW-1:0] v);
    return {{(PW-SW){v[SW-1]}}, v};
  endfunction

  function automatic logic signed [PW-1:0] ext_o(input logic signed [OW-1:0] v);
    return {{(PW-OW){v[OW-1]}}, v};
  endfunction

  function automatic logic signed [SW-1:0] sat_s(input logic signed [PW-1:0] v);
    logic signed [PW-1:0] c;
    c = (v > S_MAX) ? S_MAX : (v < S_MIN) ? S_MIN : v;
    return c[SW-1:0];
  endfunction

  function automatic logic signed [OW-1:0] sat_o(input logic signed [PW-1:0] v);
    logic signed [PW-1:0] c;
    c = (v > O_MAX) ? O_MAX : (v < O_MIN) ? O_MIN : v;
    return c[OW-1:0];
  endfunction

  function automatic logic signed [PW-1:0] k1_mul(input logic signed [SW-1:0] v);
    logic signed [PW-1:0] acc, ve;
    acc = '0;
    ve  = ext_s(v);
    for (int i = 0; i < K1_W; i++) begin
      if (K1_POS[i]) acc = acc + (ve <<< i);
      if (K1_NEG[i]) acc = acc - (ve <<< i);
    end
    return acc >>> K1_FRAC;
  endfunction

  assign x_w   = {in_sample, {FRAC{1'b0}}};
  assign a_nx  = sat_s(ext_s(a_q) - (ext_s(a_q) >>> DAMP_SH) - k1_mul(b_q) + ext_o(x_w));
  assign b_nx  = sat_s(ext_s(b_q) + k1_mul(a_nx));
  assign bp_nx = sat_o((ext_s(a_nx) + ext_s(a_q)) >>> (DAMP_SH + 1));
  assign nt_nx = sat_o(ext_o(x_w) - ext_o(bp_nx));

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q       <= '0;
      b_q       <= '0;
      bp_out    <= '0;
      notch_out <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        a_q       <= a_nx;
        b_q       <= b_nx;
        bp_out    <= bp_nx;
        notch_out <= nt_nx;
      end
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!out_valid && bp_out == '0 && notch_out == '0 && a_q == '0 && b_q == '0)); // R1
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R2
  AST_IDLE_STATE_HOLD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> ($stable(a_q) && $stable(b_q))); // R8
  AST_IDLE_OUT_HOLD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> ($stable(bp_out) && $stable(notch_out))); // R8
endmodule

// File: tb/sim_ldi_notch_cell.sv
`timescale 1ns/1ps
module sim_ldi_notch_cell;
  localparam int ADC_W = 12;
  localparam int FRAC  = 14;
  localparam int OW    = ADC_W + FRAC;
  localparam int SW    = OW + 4;
  localparam longint K1 = 64'sd10112;
  localparam int IDLE  = 9999;
  localparam int NVEC  = 24;
  localparam int VEC [NVEC] = '{1000, 0, 0, 0, IDLE, 0, 0, -2048, IDLE, IDLE, 2047, 2047,
                               0, -1, 1, 500, -500, 0, IDLE, 0, 0, 1234, -777, 0};

  logic clk = 0, rst = 1, in_valid = 0;
  logic signed [ADC_W-1:0] in_sample = '0;
  logic out_valid;
  logic signed [OW-1:0] bp_out, notch_out;
  int checks = 0, fails = 0;
  longint ma = 0, mb = 0, mbp = 0, mnt = 0;
  bit mv = 0;
  bit seen_clamp = 0;

  always #2.5 clk = ~clk;

  ldi_notch_cell u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
                     .out_valid(out_valid), .bp_out(bp_out), .notch_out(notch_out));

  function automatic longint sat(input longint v, input int w);
    longint mx, mn;
    mx = (64'sd1 <<< (w - 1)) - 1;
    mn = -(64'sd1 <<< (w - 1));
    return (v > mx) ? mx : (v < mn) ? mn : v;
  endfunction

  task automatic model(input int s, input bit v);
    longint x, an;
    mv = v;
    if (v) begin
      x   = longint'(s) * 16384;
      an  = sat(ma - (ma >>> 3) - ((mb * K1) >>> 14) + x, SW);
      mb  = sat(mb + ((an * K1) >>> 14), SW);
      mbp = sat((an + ma) >>> 4, OW);
      mnt = sat(x - mbp, OW);
      ma  = an;
    end
  endtask

  task automatic check(input string req, input longint exp_bp, input longint exp_nt, input bit exp_v);
    checks++;
    if (out_valid !== exp_v || longint'(bp_out) != exp_bp || longint'(notch_out) != exp_nt) begin
      fails++;
      $display("FAIL %s: got v=%0b bp=%0d nt=%0d, expected v=%0b bp=%0d nt=%0d",
               req, out_valid, bp_out, notch_out, exp_v, exp_bp, exp_nt);
    end
  endtask

  task automatic step(input int s, input bit v, input string req);
    in_valid  = v;
    in_sample = v ? s[ADC_W-1:0] : '0;
    model(s, v);
    @(posedge clk);
    @(negedge clk);
    check(req, mbp, mnt, mv);
  endtask

  task automatic do_reset();
    rst = 1; in_valid = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    ma = 0; mb = 0; mbp = 0; mnt = 0;
    check("R1 reset state", 0, 0, 0);
    rst = 0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R3 first sample -1 after reset, exact raw values
    step(-1, 1, "R3 alignment");
    check("R3 explicit", -1024, -15360, 1);
    do_reset();
    // R4 R5 R6 R7 R8 table of stimuli
    foreach (VEC[i]) begin
      if (VEC[i] == IDLE) step(0, 0, "R8 idle hold");
      else step(VEC[i], 1, "R4 R5 R6 R7 recurrence");
    end
    // R2 valid toggling
    step(300, 1, "R2 valid");
    step(0, 0, "R2 no valid");
    step(-300, 1, "R2 valid again");
    // R9 resonant full-scale square wave, period 10
    for (int n = 0; n < 400; n++) begin
      step(((n % 10) < 5) ? 2047 : -2048, 1, "R9 saturation");
      if (longint'(bp_out) == (64'sd1 <<< (OW - 1)) - 1 || longint'(bp_out) == -(64'sd1 <<< (OW - 1)))
        seen_clamp = 1;
    end
    checks++;
    if (!seen_clamp) begin
      fails++;
      $display("FAIL R9: got clamp_seen=0, expected 1");
    end
    // R10 reset mid-stream, then known first response
    rst = 1; in_valid = 1; in_sample = 12'sd100;
    @(posedge clk);
    @(negedge clk);
    ma = 0; mb = 0; mbp = 0; mnt = 0;
    check("R10 mid-stream reset", 0, 0, 0);
    rst = 0;
    step(-1, 1, "R10 post-reset response");
    check("R10 explicit", -1024, -15360, 1);
    step(1000, 1, "R10 continue");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule